// File: doc/BRIEF.md
# Codec Operating Mode and Clock Source Controller

This block sits beside a per-channel voice codec and works out how the channel should run from nothing more than the activity on its timing pins. It watches the transmit and receive frame syncs, the two master clocks and a receive bit clock pin. The bit clock pin also serves as a clock-select strap. The receive master clock pin doubles as a power-down request. Every pin is passed through a synchroniser on a free-running reference clock and is classified as either toggling or held at a static level.

From that classification the block settles on one of four operating modes: full duplex, transmit half-channel, receive half-channel or powered down. It picks which master clock drives the internal timing and whether the receive path borrows the transmit bit clock. It reports the master clock frequency that the strap and the companding law imply. It also raises enables for each direction. After a wake-up it keeps the transmit data and timeslot drivers inhibited until the second transmit frame sync has been seen. Analog effects such as holding the receive output at analog ground appear here only as flags.

Top module: `codec_mode_clk_ctrl`

## Requirements
- R1: Each monitored pin is synchronised through SYNC_STAGES flops. It counts as toggling while its synchronised value has changed within the last ACT_WINDOW reference cycles, and as static otherwise. A static pin's level is its synchronised value.
- R2: During and right after reset, `mode` is 3 (powered down), `pwr_down` is 1, and `tx_en`, `rx_en`, `tx_oe` and `gain_oe` are all 0.
- R3: When powered up, `mode` is 0 (full duplex) if both frame syncs toggle, 1 (transmit half-channel) if only the transmit frame sync toggles, and 2 (receive half-channel) if only the receive frame sync toggles. If neither toggles, the last of these three modes is kept.
- R4: `mclk_sel` is 1 (receive master clock) only in receive half-channel mode while the receive master clock pin toggles. Otherwise it is 0 (transmit master clock).
- R5: `bclk_sel` is 1 (transmit bit clock serves both directions) whenever the receive bit clock pin is static, and 0 while it toggles.
- R6: With the mu-law setting, `freq_2048` is 1 only when the strap pin is static low. With the A-law setting, `freq_2048` is 0 only when the strap pin is static low. A value of 0 means 1.536/1.544 MHz and a value of 1 means 2.048 MHz.
- R7: The block powers down once PD_TIMEOUT reference cycles pass with no edge on either frame sync. Any frame sync edge restarts that count.
- R8: The block is powered down while the receive master clock/power-down pin is static high.
- R9: The block powers up one cycle after a frame sync edge reaches the synchronised domain, provided the power-down pin is not static high.
- R10: `tx_oe` stays 0 after power-up until the second rising edge of the transmit frame sync seen while powered up. From then on it follows `tx_en`.
- R11: `tx_en` is 1 in modes 0 and 1. `rx_en` is 1 in modes 0 and 2. `rx_mute` is the inverse of `rx_en`, so receive data is ignored and the receive output is flagged to analog ground in transmit half-channel mode and in power-down.
- R12: `gain_oe` is 0 and `tx_oe` is 0 whenever `pwr_down` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for all detection |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_fs | input | 1 | Transmit frame sync pin |
| rx_fs | input | 1 | Receive frame sync pin |
| tx_mclk | input | 1 | Transmit master clock pin |
| rx_mclk_pd | input | 1 | Receive master clock pin, static high requests power-down |
| rx_bclk_sel | input | 1 | Receive bit clock pin, static level is a frequency strap |
| mode | output | 2 | 0 full duplex, 1 transmit half, 2 receive half, 3 powered down |
| pwr_down | output | 1 | Block is powered down |
| mclk_sel | output | 1 | 1 selects the receive master clock, 0 the transmit one |
| bclk_sel | output | 1 | 1 makes the transmit bit clock serve both directions |
| freq_2048 | output | 1 | Expected master clock: 1 for 2.048 MHz, 0 for 1.536/1.544 MHz |
| tx_en | output | 1 | Transmit path enabled |
| rx_en | output | 1 | Receive data accepted |
| rx_mute | output | 1 | Receive output held at analog ground |
| tx_oe | output | 1 | Transmit data and timeslot drivers enabled |
| gain_oe | output | 1 | Transmit gain amplifier output enabled |

## Verification
The bench drives the pins through a sequence of patterns: all pins toggling, each frame sync stopped on its own, the receive master clock stopped in receive half-channel mode, the strap held low and then high, both frame syncs stopped, and the power-down pin held high. The sequence is run on a mu-law and an A-law instance side by side. The all-toggling and single-sync patterns separate the three running modes and the clock selections. The strap levels separate the two companding laws. The stop of both frame syncs separates holding the last mode from the timeout, and the power-down pin separates forced power-down from timeout power-down. Each wake-up checks that the transmit drivers stay off until the second transmit frame sync.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

   typedef enum logic [1:0] {
      MODE_FULL = 2'd0,
      MODE_TXH  = 2'd1,
      MODE_RXH  = 2'd2,
      MODE_PDN  = 2'd3
   } op_mode_t;

   localparam int CH_TXFS  = 0;
   localparam int CH_RXFS  = 1;
   localparam int CH_TXMCK = 2;
   localparam int CH_RXMCK = 3;
   localparam int CH_RXBCK = 4;
   localparam int NUM_CH   = 5;

endpackage

// File: rtl/cmc_activity.sv
module cmc_activity #(
   parameter int WIN         = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic active,
   output logic level,
   output logic edge_seen,
   output logic rise
);
   localparam int CW  = $clog2(WIN + 1);
   localparam int MSB = SYNC_STAGES - 1;

   if (WIN < 2) begin : g_bad_win
      $error("cmc_activity: WIN must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cmc_activity: SYNC_STAGES must be at least 2");
   end

   logic [MSB:0]  sync_q;
   logic          last_q;
   logic [CW-1:0] quiet_q;

   assign edge_seen = sync_q[MSB] ^ last_q;
   assign rise      = sync_q[MSB] & ~last_q;
   assign level     = sync_q[MSB];
   assign active    = (quiet_q < CW'(WIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '0;
         last_q  <= 1'b0;
         quiet_q <= CW'(WIN);
      end else begin
         sync_q <= {sync_q[MSB-1:0], pin};
         last_q <= sync_q[MSB];
         if (edge_seen)
            quiet_q <= '0;
         else if (quiet_q != CW'(WIN))
            quiet_q <= quiet_q + 1'b1;
      end
   end

   // R1
   edge_marks_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |=> active);

endmodule

// File: rtl/cmc_pwr_ctl.sv
module cmc_pwr_ctl #(
   parameter int PD_TIMEOUT     = 16384,
   parameter int RELEASE_PULSES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_edge_any,
   input  logic tx_fs_rise,
   input  logic pin_pd_hold,
   output logic pwr_down,
   output logic tx_release
);
   localparam int TW = $clog2(PD_TIMEOUT + 1);
   localparam int RW = $clog2(RELEASE_PULSES + 1);

   if (PD_TIMEOUT < 1) begin : g_bad_to
      $error("cmc_pwr_ctl: PD_TIMEOUT must be positive");
   end
   if (RELEASE_PULSES < 1) begin : g_bad_rel
      $error("cmc_pwr_ctl: RELEASE_PULSES must be positive");
   end

   logic [TW-1:0] idle_q;
   logic [RW-1:0] rel_q;
   logic          timed_out;

   assign timed_out  = (idle_q == TW'(PD_TIMEOUT));
   assign pwr_down   = timed_out | pin_pd_hold;
   assign tx_release = (rel_q == RW'(RELEASE_PULSES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= TW'(PD_TIMEOUT);
      end else if (fs_edge_any) begin
         idle_q <= '0;
      end else if (!timed_out) begin
         idle_q <= idle_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q <= '0;
      end else if (pwr_down) begin
         rel_q <= '0;
      end else if (tx_fs_rise && !tx_release) begin
         rel_q <= rel_q + 1'b1;
      end
   end

   // R7
   fs_edge_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs_edge_any |=> !timed_out);

   // R10
   pd_clears_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> (rel_q == '0));

endmodule

// File: rtl/cmc_mode_dec.sv
module cmc_mode_dec
   import cmc_pkg::*;
#(
   parameter bit A_LAW = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_fs_act,
   input  logic       rx_fs_act,
   input  logic       rx_mck_act,
   input  logic       rx_bck_act,
   input  logic       rx_bck_lvl,
   input  logic       pwr_down,
   input  logic       tx_release,
   output logic [1:0] mode,
   output logic       mclk_sel,
   output logic       bclk_sel,
   output logic       freq_2048,
   output logic       tx_en,
   output logic       rx_en,
   output logic       rx_mute,
   output logic       tx_oe,
   output logic       gain_oe
);
   op_mode_t held_q;
   op_mode_t run_mode;
   op_mode_t cur_mode;
   logic     clksel_hi;

   always_comb begin
      unique case ({tx_fs_act, rx_fs_act})
         2'b11:   run_mode = MODE_FULL;
         2'b10:   run_mode = MODE_TXH;
         2'b01:   run_mode = MODE_RXH;
         default: run_mode = held_q;
      endcase
   end

   assign cur_mode = pwr_down ? MODE_PDN : run_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= MODE_FULL;
      else if (!pwr_down)
         held_q <= run_mode;
   end

   assign mode     = cur_mode;
   assign mclk_sel = (cur_mode == MODE_RXH) && rx_mck_act;
   assign bclk_sel = ~rx_bck_act;
   assign tx_en    = (cur_mode == MODE_FULL) || (cur_mode == MODE_TXH);
   assign rx_en    = (cur_mode == MODE_FULL) || (cur_mode == MODE_RXH);
   assign rx_mute  = ~rx_en;
   assign tx_oe    = tx_en & tx_release;
   assign gain_oe  = ~pwr_down;

   assign clksel_hi = rx_bck_act | rx_bck_lvl;

   if (A_LAW) begin : g_alaw
      assign freq_2048 = clksel_hi;
   end else begin : g_mulaw
      assign freq_2048 = ~clksel_hi;
   end

   // R10
   oe_needs_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_oe) |-> !$past(pwr_down));

endmodule

// File: rtl/codec_mode_clk_ctrl.sv
module codec_mode_clk_ctrl
   import cmc_pkg::*;
#(
   parameter int ACT_WINDOW     = 64,
   parameter int SYNC_STAGES    = 2,
   parameter int PD_TIMEOUT     = 16384,
   parameter int RELEASE_PULSES = 2,
   parameter bit A_LAW          = 1'b0
) (
   input  logic       ref_clk,
   input  logic       rst_n,
   input  logic       tx_fs,
   input  logic       rx_fs,
   input  logic       tx_mclk,
   input  logic       rx_mclk_pd,
   input  logic       rx_bclk_sel,
   output logic [1:0] mode,
   output logic       pwr_down,
   output logic       mclk_sel,
   output logic       bclk_sel,
   output logic       freq_2048,
   output logic       tx_en,
   output logic       rx_en,
   output logic       rx_mute,
   output logic       tx_oe,
   output logic       gain_oe
);
   if (PD_TIMEOUT <= ACT_WINDOW) begin : g_bad_timing
      $error("codec_mode_clk_ctrl: PD_TIMEOUT must exceed ACT_WINDOW");
   end

   logic [NUM_CH-1:0] raw_pins;
   logic [NUM_CH-1:0] act;
   logic [NUM_CH-1:0] lvl;
   logic [NUM_CH-1:0] edg;
   logic [NUM_CH-1:0] rse;
   logic              pin_pd_hold;
   logic              tx_release;
   logic              unused_pin_bits;

   assign raw_pins = {rx_bclk_sel, rx_mclk_pd, tx_mclk, rx_fs, tx_fs};

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pin
      cmc_activity #(
         .WIN         (ACT_WINDOW),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_act (
         .clk       (ref_clk),
         .rst_n     (rst_n),
         .pin       (raw_pins[ch]),
         .active    (act[ch]),
         .level     (lvl[ch]),
         .edge_seen (edg[ch]),
         .rise      (rse[ch])
      );
   end

   assign unused_pin_bits = &{act[CH_TXMCK], lvl[CH_TXMCK:CH_TXFS],
                              rse[NUM_CH-1:CH_RXFS], edg[NUM_CH-1:CH_TXMCK]};

   assign pin_pd_hold = lvl[CH_RXMCK] & ~act[CH_RXMCK];

   cmc_pwr_ctl #(
      .PD_TIMEOUT     (PD_TIMEOUT),
      .RELEASE_PULSES (RELEASE_PULSES)
   ) u_pwr (
      .clk         (ref_clk),
      .rst_n       (rst_n),
      .fs_edge_any (edg[CH_TXFS] | edg[CH_RXFS]),
      .tx_fs_rise  (rse[CH_TXFS]),
      .pin_pd_hold (pin_pd_hold),
      .pwr_down    (pwr_down),
      .tx_release  (tx_release)
   );

   cmc_mode_dec #(
      .A_LAW (A_LAW)
   ) u_mode (
      .clk        (ref_clk),
      .rst_n      (rst_n),
      .tx_fs_act  (act[CH_TXFS]),
      .rx_fs_act  (act[CH_RXFS]),
      .rx_mck_act (act[CH_RXMCK]),
      .rx_bck_act (act[CH_RXBCK]),
      .rx_bck_lvl (lvl[CH_RXBCK]),
      .pwr_down   (pwr_down),
      .tx_release (tx_release),
      .mode       (mode),
      .mclk_sel   (mclk_sel),
      .bclk_sel   (bclk_sel),
      .freq_2048  (freq_2048),
      .tx_en      (tx_en),
      .rx_en      (rx_en),
      .rx_mute    (rx_mute),
      .tx_oe      (tx_oe),
      .gain_oe    (gain_oe)
   );

   // R8
   pin_hold_forces_pd_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (lvl[CH_RXMCK] && !act[CH_RXMCK]) |-> (mode == 2'd3));

endmodule

// File: tb/sim_codec_mode_clk_ctrl.sv
`timescale 1ns/1ps
module sim_codec_mode_clk_ctrl;
   localparam int WIN = 16;
   localparam int PDT = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [4:0] val = 5'b0;
   logic [4:0] tog = 5'b0;
   logic [4:0] lvl = 5'b0;
   int per [5] = '{6, 6, 1, 1, 2};
   int cyc = 0;

   logic [1:0] mode0, mode1;
   logic pd0, pd1, ms0, ms1, bs0, bs1, fq0, fq1, te0, te1, re0, re1;
   logic rm0, rm1, oe0, oe1, go0, go1;

   codec_mode_clk_ctrl #(.ACT_WINDOW(WIN), .PD_TIMEOUT(PDT), .A_LAW(1'b0)) u0 (
      .ref_clk(clk), .rst_n(rst_n), .tx_fs(val[0]), .rx_fs(val[1]), .tx_mclk(val[2]),
      .rx_mclk_pd(val[3]), .rx_bclk_sel(val[4]), .mode(mode0), .pwr_down(pd0),
      .mclk_sel(ms0), .bclk_sel(bs0), .freq_2048(fq0), .tx_en(te0), .rx_en(re0),
      .rx_mute(rm0), .tx_oe(oe0), .gain_oe(go0));

   codec_mode_clk_ctrl #(.ACT_WINDOW(WIN), .PD_TIMEOUT(PDT), .A_LAW(1'b1)) u1 (
      .ref_clk(clk), .rst_n(rst_n), .tx_fs(val[0]), .rx_fs(val[1]), .tx_mclk(val[2]),
      .rx_mclk_pd(val[3]), .rx_bclk_sel(val[4]), .mode(mode1), .pwr_down(pd1),
      .mclk_sel(ms1), .bclk_sel(bs1), .freq_2048(fq1), .tx_en(te1), .rx_en(re1),
      .rx_mute(rm1), .tx_oe(oe1), .gain_oe(go1));

   int ntests = 0;
   int nfail = 0;
   bit done = 0;

   task automatic chk(input string req, input int act, input int exp);
      ntests++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // stimulus: each pin either toggles at its own period or holds a level
   always @(negedge clk) begin
      cyc++;
      for (int i = 0; i < 5; i++) begin
         if (tog[i]) begin
            if (cyc % per[i] == 0) val[i] = ~val[i];
         end else begin
            val[i] = lvl[i];
         end
      end
   end

   // behavioural reference: sample history and elapsed-cycle counters
   bit h1 [5], h2 [5], h3 [5];
   int since [5];
   int idle, rel, held;
   bit ev [5];

   function automatic bit m_act(input int i);
      return since[i] < WIN;
   endfunction
   function automatic bit m_pd();
      return (idle >= PDT) || (h2[3] && !m_act(3));
   endfunction
   function automatic int m_run();
      if (m_act(0) && m_act(1)) return 0;
      if (m_act(0)) return 1;
      if (m_act(1)) return 2;
      return held;
   endfunction
   function automatic int m_mode();
      return m_pd() ? 3 : m_run();
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 5; i++) begin
            h1[i] = 0; h2[i] = 0; h3[i] = 0; since[i] = WIN;
         end
         idle = PDT; rel = 0; held = 0;
      end else begin
         bit opd;
         int orun;
         for (int i = 0; i < 5; i++) ev[i] = (h2[i] != h3[i]);
         opd = m_pd();
         orun = m_run();
         if (!opd) held = orun;
         if (opd) rel = 0;
         else if (h2[0] && !h3[0] && rel < 2) rel++;
         if (ev[0] || ev[1]) idle = 0;
         else if (idle < PDT) idle++;
         for (int i = 0; i < 5; i++) begin
            if (ev[i]) since[i] = 0;
            else if (since[i] < WIN) since[i]++;
            h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = val[i];
         end
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int em;
         bit hi, ten, ren;
         em  = m_mode();
         hi  = m_act(4) || h2[4];
         ten = (em == 0) || (em == 1);
         ren = (em == 0) || (em == 2);
         chk("R3 mode u0", mode0, em);
         chk("R3 mode u1", mode1, em);
         chk("R7 R8 R9 pwr_down", pd0, m_pd());
         chk("R4 mclk_sel", ms0, (em == 2) && m_act(3));
         chk("R1 R5 bclk_sel", bs0, !m_act(4));
         chk("R6 freq mu-law", fq0, !hi);
         chk("R6 freq A-law", fq1, hi);
         chk("R11 tx_en", te0, ten);
         chk("R11 rx_en", re0, ren);
         chk("R11 rx_mute", rm0, !ren);
         chk("R10 tx_oe", oe0, ten && rel == 2);
         chk("R12 gain_oe", go0, !m_pd());
      end
   end

   task automatic drive(input logic [4:0] t, input logic [4:0] l);
      tog = t;
      lvl = l;
   endtask

   task automatic summary();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      chk("R2 mode", mode0, 3);
      chk("R2 pwr_down", pd0, 1);
      chk("R2 tx_oe", oe0, 0);
      chk("R2 gain_oe", go0, 0);
      chk("R2 tx_en rx_en", te0 | re0, 0);

      // everything toggling: full duplex
      drive(5'b11111, 5'b00000);
      repeat (100) @(negedge clk);
      chk("R3 full duplex", mode0, 0);
      chk("R4 tx master clock in full duplex", ms0, 0);
      chk("R5 receive bit clock toggling", bs0, 0);
      chk("R6 toggling strap mu-law", fq0, 0);
      chk("R6 toggling strap A-law", fq1, 1);
      chk("R10 tx_oe after two syncs", oe0, 1);

      // receive frame sync held low: transmit half-channel
      drive(5'b11101, 5'b00000);
      repeat (60) @(negedge clk);
      chk("R3 transmit half", mode0, 1);
      chk("R11 rx_mute in transmit half", rm0, 1);

      // transmit frame sync held low, receive toggling
      drive(5'b11110, 5'b00000);
      repeat (60) @(negedge clk);
      chk("R3 receive half", mode0, 2);
      chk("R4 rx master clock selected", ms0, 1);
      chk("R11 tx_oe off in receive half", oe0, 0);

      // receive master clock stopped low
      drive(5'b10110, 5'b00000);
      repeat (60) @(negedge clk);
      chk("R4 falls back to tx master clock", ms0, 0);

      // strap held low, then high
      drive(5'b00110, 5'b00000);
      repeat (60) @(negedge clk);
      chk("R5 static strap shares tx bit clock", bs0, 1);
      chk("R6 low strap mu-law", fq0, 1);
      chk("R6 low strap A-law", fq1, 0);
      drive(5'b00110, 5'b10000);
      repeat (60) @(negedge clk);
      chk("R6 high strap mu-law", fq0, 0);
      chk("R6 high strap A-law", fq1, 1);

      // both frame syncs stopped: hold, then timeout
      drive(5'b00100, 5'b10000);
      repeat (60) @(negedge clk);
      chk("R3 last mode held", mode0, 2);
      chk("R7 not yet timed out", pd0, 0);
      repeat (200) @(negedge clk);
      chk("R7 timeout power-down", pd0, 1);
      chk("R12 gain off in power-down", go0, 0);

      // wake-up
      drive(5'b11111, 5'b00000);
      for (int k = 0; k < 50 && pd0; k++) @(negedge clk);
      chk("R9 powered up", pd0, 0);
      chk("R10 tx_oe held off at wake", oe0, 0);
      repeat (100) @(negedge clk);
      chk("R10 tx_oe released", oe0, 1);

      // power-down pin held high
      drive(5'b10111, 5'b01000);
      repeat (60) @(negedge clk);
      chk("R8 pin forces power-down", pd0, 1);
      chk("R12 tx_oe off in power-down", oe0, 0);
      drive(5'b11111, 5'b00000);
      repeat (100) @(negedge clk);
      chk("R9 wake after pin released", pd0, 0);
      summary();
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: run did not complete, actual 0 expected 1");
         summary();
      end
   end

endmodule